// File: doc/BRIEF.md
# Restricted-Addressing Register File

This block is the general register store of a small CPU datapath: thirty-two byte-wide registers behind two combinational read ports, one byte write port and one 16-bit pair write port. The pair port carries three kinds of work: copying one aligned register pair onto another, adding a small constant to a 16-bit pair or subtracting one from it, and storing a two-byte multiply result. The write address rules differ for each kind of work, and the block enforces them itself.

A byte write flagged as an immediate-class write may only land in the upper half of the file. A pair copy needs even low indices at both ends. A word add or subtract works only on the four pairs at the top of the file. A request that breaks any rule is refused as a whole: nothing is written in that cycle, and an error output rises for the following cycle. A multiply result always lands in the lowest pair, whatever addresses come with it. Inside a pair, the even register holds the low byte.

Top module: `pairwise_regfile`

## Requirements
- R1: After a synchronous reset, all 32 registers read as 0x00, `op_error` is 0 and `word_carry` is 0.
- R2: Both read ports are combinational. A written value appears on either port, at any address, after the rising edge that performs the write.
- R3: With `byte_we`=1 and `byte_imm`=0, `byte_data` is written to any register 0 to 31.
- R4: With `byte_we`=1 and `byte_imm`=1, a write to registers 16 to 31 succeeds. A write to registers 0 to 15 is refused.
- R5: `pair_op`=1 (copy) writes the pair at even `pair_src` into the pair at even `pair_dst`. The low byte goes to the even register and the high byte to the odd one, and the source pair is left unchanged.
- R6: A copy with an odd `pair_src` or an odd `pair_dst` is refused.
- R7: `pair_op`=2 (word add) adds the 6-bit `pair_imm` (0 to 63) to the 16-bit pair at `pair_dst` and writes the sum back. The carry out of bit 15 is registered on `word_carry`.
- R8: `pair_op`=3 (word subtract) subtracts `pair_imm` from the pair at `pair_dst` and writes the result back. `word_carry` registers the borrow, which is 1 when the pair value was less than the constant.
- R9: A word add or subtract is refused unless `pair_dst` is 24, 26, 28 or 30.
- R10: `pair_op`=4 (multiply store) writes `mul_data[15:8]` to register 1 and `mul_data[7:0]` to register 0, whatever `pair_dst` and `pair_src` hold.
- R11: When an accepted byte write and an accepted pair write target the same register in one cycle, the pair write wins. A byte write to a register outside the pair still takes place.
- R12: A refused request suppresses every write of that cycle, on both ports. `op_error` is 1 in the cycle after it and 0 again after a following legal or idle cycle.
- R13: `word_carry` keeps its value through every cycle that has no accepted word add or subtract. `pair_op` values 0 and 5 to 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_addr | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data, combinational |
| rd_b_addr | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data, combinational |
| byte_we | input | 1 | Byte write request |
| byte_imm | input | 1 | Byte write belongs to the immediate class (upper half only) |
| byte_addr | input | 5 | Byte write register index |
| byte_data | input | 8 | Byte write data |
| pair_op | input | 3 | 0 none, 1 copy, 2 word add, 3 word subtract, 4 multiply store |
| pair_dst | input | 5 | Destination low register index (copy, word add/subtract) |
| pair_src | input | 5 | Source low register index (copy) |
| pair_imm | input | 6 | Word add/subtract constant |
| mul_data | input | 16 | Multiply result to store |
| word_carry | output | 1 | Carry or borrow of the last accepted word operation |
| op_error | output | 1 | High for one cycle after a refused request |

## Verification
The bench builds the block with its default parameters: 32 registers of 8 bits, a 6-bit constant, the immediate window starting at 16, and four word pairs starting at 24. At these values the boundary indices 15/16, 22/24 and the odd index 25 can be driven directly. The largest constant, 63, pushes 0xFFF0 past bit 15, and a constant above a small pair value forces a borrow. The same scoreboard sweep follows every operation, so it also catches stray writes to registers that the operation should not touch.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  // pair-port operation kinds; unlisted codes are idle
  typedef enum logic [2:0] {
    PO_NONE = 3'd0,
    PO_COPY = 3'd1,
    PO_ADDW = 3'd2,
    PO_SUBW = 3'd3,
    PO_MUL  = 3'd4
  } pair_op_e;
endpackage

// File: rtl/rf_legal.sv
`timescale 1ns/1ps
module rf_legal
  import rf_pkg::*;
#(
  parameter int AW         = 5,
  parameter int IMM_LO     = 16,
  parameter int WORD_BASE  = 24,
  parameter int WORD_PAIRS = 4
) (
  input  logic          byte_we,
  input  logic          byte_imm,
  input  logic [AW-1:0] byte_addr,
  input  pair_op_e      pop,
  input  logic [AW-1:0] pair_dst,
  input  logic [AW-1:0] pair_src,
  output logic          byte_bad,
  output logic          pair_bad,
  output logic          rule_break
);
  localparam int WORD_TOP = WORD_BASE + 2 * WORD_PAIRS;

  logic in_word_window;

  always_comb begin
    in_word_window = !pair_dst[0] && (int'(pair_dst) >= WORD_BASE) &&
                     (int'(pair_dst) < WORD_TOP);
    byte_bad = byte_we && byte_imm && (int'(byte_addr) < IMM_LO);
    case (pop)
      PO_COPY:          pair_bad = pair_dst[0] || pair_src[0];
      PO_ADDW, PO_SUBW: pair_bad = !in_word_window;
      default:          pair_bad = 1'b0;
    endcase
    rule_break = byte_bad || pair_bad;
  end
endmodule

// File: rtl/rf_word_alu.sv
`timescale 1ns/1ps
module rf_word_alu #(
  parameter int WW = 16,
  parameter int IW = 6
) (
  input  logic [WW-1:0] value,
  input  logic [IW-1:0] imm,
  input  logic          sub,
  output logic [WW-1:0] result,
  output logic          cout
);
  // one extra bit holds the carry (add) or the borrow (subtract)
  function automatic logic [WW:0] word_step(input logic [WW-1:0] v,
                                            input logic [IW-1:0] k,
                                            input logic          minus);
    logic [WW:0] ext_v;
    logic [WW:0] ext_k;
    ext_v = {1'b0, v};
    ext_k = (WW + 1)'(k);
    return minus ? (ext_v - ext_k) : (ext_v + ext_k);
  endfunction

  logic [WW:0] step;

  always_comb begin
    step   = word_step(value, imm, sub);
    result = step[WW-1:0];
    cout   = step[WW];
  end

  always_comb begin
    AST_STEP_INVERTS: assert (sub ? ((result + WW'(imm)) == value)
                                  : ((result - WW'(imm)) == value)); // R7
  end
endmodule

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
module rf_bank #(
  parameter int NREG = 32,
  parameter int DW   = 8,
  parameter int AW   = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     byte_en,
  input  logic [AW-1:0]            byte_addr,
  input  logic [DW-1:0]            byte_data,
  input  logic                     pair_en,
  input  logic [AW-2:0]            pair_idx,
  input  logic [2*DW-1:0]          pair_data,
  input  logic [AW-2:0]            src_idx,
  input  logic [AW-2:0]            dst_idx,
  output logic [2*DW-1:0]          src_word,
  output logic [2*DW-1:0]          dst_word,
  output logic [NREG-1:0][DW-1:0]  bank_o
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    // pair write checked first: it wins a same-register conflict
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (pair_en && (int'(pair_idx) == g / 2)) begin
        regs[g] <= pair_data[(g % 2) * DW +: DW];
      end else if (byte_en && (int'(byte_addr) == g)) begin
        regs[g] <= byte_data;
      end
    end
    assign bank_o[g] = regs[g];
  end

  assign src_word = {regs[{src_idx, 1'b1}], regs[{src_idx, 1'b0}]};
  assign dst_word = {regs[{dst_idx, 1'b1}], regs[{dst_idx, 1'b0}]};
endmodule

// File: rtl/pairwise_regfile.sv
`timescale 1ns/1ps
module pairwise_regfile
  import rf_pkg::*;
#(
  parameter int NREG       = 32,
  parameter int DW         = 8,
  parameter int IW         = 6,
  parameter int IMM_LO     = 16,
  parameter int WORD_BASE  = 24,
  parameter int WORD_PAIRS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] rd_a_addr,
  output logic [DW-1:0]           rd_a_data,
  input  logic [$clog2(NREG)-1:0] rd_b_addr,
  output logic [DW-1:0]           rd_b_data,
  input  logic                    byte_we,
  input  logic                    byte_imm,
  input  logic [$clog2(NREG)-1:0] byte_addr,
  input  logic [DW-1:0]           byte_data,
  input  logic [2:0]              pair_op,
  input  logic [$clog2(NREG)-1:0] pair_dst,
  input  logic [$clog2(NREG)-1:0] pair_src,
  input  logic [IW-1:0]           pair_imm,
  input  logic [2*DW-1:0]         mul_data,
  output logic                    word_carry,
  output logic                    op_error
);
  localparam int AW = $clog2(NREG);
  localparam int PW = 2 * DW;

  pair_op_e pop;
  logic is_copy, is_word, is_mul, is_sub;
  logic byte_bad, pair_bad, rule_break, accept;
  logic [AW-2:0] dst_idx, src_idx, wr_idx;
  logic [PW-1:0] src_word, dst_word, alu_word, pair_data;
  logic alu_cout;
  logic [NREG-1:0][DW-1:0] bank;

  // named events for the checks below
  logic byte_fire, pair_fire, word_fire, mul_fire, copy_fire;
  logic overlap_now, src_untouched_now;

  assign pop     = pair_op_e'(pair_op);
  assign is_copy = (pop == PO_COPY);
  assign is_word = (pop == PO_ADDW) || (pop == PO_SUBW);
  assign is_sub  = (pop == PO_SUBW);
  assign is_mul  = (pop == PO_MUL);

  rf_legal #(
    .AW(AW), .IMM_LO(IMM_LO), .WORD_BASE(WORD_BASE), .WORD_PAIRS(WORD_PAIRS)
  ) u_legal (
    .byte_we(byte_we), .byte_imm(byte_imm), .byte_addr(byte_addr),
    .pop(pop), .pair_dst(pair_dst), .pair_src(pair_src),
    .byte_bad(byte_bad), .pair_bad(pair_bad), .rule_break(rule_break)
  );

  assign accept  = !rule_break && !rst;
  assign dst_idx = pair_dst[AW-1:1];
  assign src_idx = pair_src[AW-1:1];
  assign wr_idx  = is_mul ? '0 : dst_idx;

  rf_word_alu #(.WW(PW), .IW(IW)) u_alu (
    .value(dst_word), .imm(pair_imm), .sub(is_sub),
    .result(alu_word), .cout(alu_cout)
  );

  always_comb begin
    case (pop)
      PO_COPY:          pair_data = src_word;
      PO_ADDW, PO_SUBW: pair_data = alu_word;
      PO_MUL:           pair_data = mul_data;
      default:          pair_data = '0;
    endcase
  end

  assign byte_fire = accept && byte_we;
  assign copy_fire = accept && is_copy;
  assign word_fire = accept && is_word;
  assign mul_fire  = accept && is_mul;
  assign pair_fire = copy_fire || word_fire || mul_fire;

  rf_bank #(.NREG(NREG), .DW(DW), .AW(AW)) u_bank (
    .clk(clk), .rst(rst),
    .byte_en(byte_fire), .byte_addr(byte_addr), .byte_data(byte_data),
    .pair_en(pair_fire), .pair_idx(wr_idx), .pair_data(pair_data),
    .src_idx(src_idx), .dst_idx(dst_idx),
    .src_word(src_word), .dst_word(dst_word), .bank_o(bank)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      word_carry <= 1'b0;
      op_error   <= 1'b0;
    end else begin
      op_error <= rule_break;
      if (word_fire) word_carry <= alu_cout;
    end
  end

  assign rd_a_data = bank[rd_a_addr];
  assign rd_b_data = bank[rd_b_addr];

  // ---- checks ----
  assign overlap_now = byte_fire && pair_fire && (byte_addr[AW-1:1] == wr_idx);
  assign src_untouched_now = copy_fire && (src_idx != dst_idx) &&
                             !(byte_fire && (byte_addr[AW-1:1] == src_idx));

  logic [AW-1:0] prev_byte_addr;
  logic [AW-2:0] prev_src_idx;
  logic [PW-1:0] prev_pair_data, prev_src_word;

  always_ff @(posedge clk) begin
    prev_byte_addr <= byte_addr;
    prev_src_idx   <= src_idx;
    prev_pair_data <= pair_data;
    prev_src_word  <= src_word;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank == '0) && !op_error && !word_carry); // R1

  AST_REJECT_FREEZES: assert property (@(posedge clk) disable iff (rst)
    op_error |-> (bank == $past(bank))); // R12

  AST_MUL_FIXED_PAIR: assert property (@(posedge clk) disable iff (rst)
    $past(mul_fire) |-> ({bank[1], bank[0]} == $past(mul_data))); // R10

  AST_COPY_KEEPS_SRC: assert property (@(posedge clk) disable iff (rst)
    $past(src_untouched_now) |->
      ({bank[{prev_src_idx, 1'b1}], bank[{prev_src_idx, 1'b0}]} == prev_src_word)); // R5

  AST_PAIR_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(overlap_now) |->
      (bank[prev_byte_addr] == (prev_byte_addr[0] ? prev_pair_data[PW-1:DW]
                                                  : prev_pair_data[DW-1:0]))); // R11

  AST_CARRY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !$past(word_fire) |-> $stable(word_carry)); // R13
endmodule

// File: tb/test_pairwise_regfile.sv
`timescale 1ns/1ps
module test_pairwise_regfile;
  localparam int NREG = 32;
  localparam int DW   = 8;
  localparam int IW   = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [4:0]  rd_a_addr = '0, rd_b_addr = '0;
  logic [7:0]  rd_a_data, rd_b_data;
  logic        byte_we = 1'b0, byte_imm = 1'b0;
  logic [4:0]  byte_addr = '0;
  logic [7:0]  byte_data = '0;
  logic [2:0]  pair_op = '0;
  logic [4:0]  pair_dst = '0, pair_src = '0;
  logic [5:0]  pair_imm = '0;
  logic [15:0] mul_data = '0;
  logic        word_carry, op_error;

  pairwise_regfile #(.NREG(NREG), .DW(DW), .IW(IW)) i_pairwise_regfile (
    .clk(clk), .rst(rst),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .byte_we(byte_we), .byte_imm(byte_imm), .byte_addr(byte_addr), .byte_data(byte_data),
    .pair_op(pair_op), .pair_dst(pair_dst), .pair_src(pair_src), .pair_imm(pair_imm),
    .mul_data(mul_data), .word_carry(word_carry), .op_error(op_error)
  );

  // scoreboard item: kind 0 error flag, 1 carry, 2 register
  typedef struct packed {
    logic [1:0] kind;
    logic [4:0] addr;
    logic [7:0] exp;
    logic [3:0] req;
  } item_t;

  item_t sbq[$];
  logic  mon_busy = 1'b0;
  logic  done = 1'b0;
  int    checks = 0, errors = 0;
  logic [7:0] mdl [NREG];
  logic  mdl_carry = 1'b0;

  // monitor: pops expected items and compares them with the ports
  initial begin
    item_t it;
    logic [7:0] act_a, act_b;
    forever begin
      wait (sbq.size() != 0);
      it = sbq.pop_front();
      mon_busy = 1'b1;
      if (it.kind == 2'd2) begin
        rd_a_addr = it.addr;
        rd_b_addr = it.addr;
      end
      #0.1;
      case (it.kind)
        2'd0:    begin act_a = {7'd0, op_error};   act_b = act_a; end
        2'd1:    begin act_a = {7'd0, word_carry}; act_b = act_a; end
        default: begin act_a = rd_a_data;          act_b = rd_b_data; end
      endcase
      checks++;
      if (act_a !== it.exp || act_b !== it.exp) begin
        errors++;
        $display("FAIL R%0d kind=%0d reg=%0d: got a=%h b=%h expected %h",
                 it.req, it.kind, it.addr, act_a, act_b, it.exp);
      end
      mon_busy = 1'b0;
    end
  end

  task automatic push_all(input logic exp_err, input logic [3:0] req);
    sbq.push_back(item_t'{2'd0, 5'd0, {7'd0, exp_err}, req});
    sbq.push_back(item_t'{2'd1, 5'd0, {7'd0, mdl_carry}, req});
    for (int i = 0; i < NREG; i++) sbq.push_back(item_t'{2'd2, 5'(i), mdl[i], req});
    wait (sbq.size() == 0 && !mon_busy);
  endtask

  // driver: applies one request for one cycle, updates the model, queues expectations
  task automatic run_op(input logic bwe, input logic bimm, input logic [4:0] ba,
                        input logic [7:0] bd, input logic [2:0] po, input logic [4:0] pd,
                        input logic [4:0] ps, input logic [5:0] pi, input logic [15:0] md,
                        input logic [3:0] req);
    logic bad;
    logic [15:0] src_w, dst_w;
    int total;
    @(negedge clk);
    byte_we = bwe; byte_imm = bimm; byte_addr = ba; byte_data = bd;
    pair_op = po; pair_dst = pd; pair_src = ps; pair_imm = pi; mul_data = md;
    @(negedge clk);
    byte_we = 1'b0; byte_imm = 1'b0; pair_op = 3'd0;
    bad = 1'b0;
    if (bwe && bimm && ba < 5'd16) bad = 1'b1;
    if (po == 3'd1 && (pd[0] || ps[0])) bad = 1'b1;
    if ((po == 3'd2 || po == 3'd3) && !(pd == 5'd24 || pd == 5'd26 || pd == 5'd28 || pd == 5'd30))
      bad = 1'b1;
    if (!bad) begin
      src_w = {mdl[{ps[4:1], 1'b1}], mdl[{ps[4:1], 1'b0}]};
      dst_w = {mdl[{pd[4:1], 1'b1}], mdl[{pd[4:1], 1'b0}]};
      if (bwe) mdl[ba] = bd;
      case (po)
        3'd1: begin mdl[pd] = src_w[7:0]; mdl[pd + 5'd1] = src_w[15:8]; end
        3'd2: begin
          total = int'(dst_w) + int'(pi);
          mdl_carry = (total > 65535);
          total = total % 65536;
          mdl[pd] = 8'(total); mdl[pd + 5'd1] = 8'(total / 256);
        end
        3'd3: begin
          total = int'(dst_w) - int'(pi);
          mdl_carry = (total < 0);
          if (total < 0) total = total + 65536;
          mdl[pd] = 8'(total); mdl[pd + 5'd1] = 8'(total / 256);
        end
        3'd4: begin mdl[0] = md[7:0]; mdl[1] = md[15:8]; end
        default: ;
      endcase
    end
    push_all(bad, req);
  endtask

  task automatic do_reset(input logic [3:0] req);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    mdl_carry = 1'b0;
    push_all(1'b0, req);
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    do_reset(4'd1);                                                   // R1 reset state
    run_op(1, 0, 5'd0,  8'hA5, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd3); // R3 low register
    run_op(1, 0, 5'd15, 8'h3C, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd3); // R3 edge of lower half
    run_op(1, 0, 5'd31, 8'h7E, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd2); // R2 both ports see it
    run_op(1, 1, 5'd16, 8'h34, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4 window low edge
    run_op(1, 1, 5'd17, 8'h12, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4
    run_op(1, 1, 5'd15, 8'h99, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4 refused at 15
    run_op(0, 0, 5'd0,  8'h00, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd12);// R12 error drops
    run_op(0, 0, 5'd0,  8'h00, 3'd1, 5'd0, 5'd16, 6'd0, 16'h0, 4'd5);// R5 copy 17:16 to 1:0
    run_op(0, 0, 5'd0,  8'h00, 3'd1, 5'd3, 5'd16, 6'd0, 16'h0, 4'd6);// R6 odd destination
    run_op(0, 0, 5'd0,  8'h00, 3'd1, 5'd4, 5'd17, 6'd0, 16'h0, 4'd6);// R6 odd source
    run_op(1, 1, 5'd24, 8'h00, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4
    run_op(1, 1, 5'd25, 8'h10, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4
    run_op(0, 0, 5'd0,  8'h00, 3'd2, 5'd24, 5'd0, 6'h0A, 16'h0, 4'd7);// R7 0x1000+0x0A
    run_op(1, 1, 5'd30, 8'hF0, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4
    run_op(1, 1, 5'd31, 8'hFF, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4
    run_op(0, 0, 5'd0,  8'h00, 3'd2, 5'd30, 5'd0, 6'd63, 16'h0, 4'd7);// R7 carry out, max constant
    run_op(1, 0, 5'd7,  8'h11, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd13);// R13 carry held
    run_op(0, 0, 5'd0,  8'h00, 3'd6, 5'd24, 5'd2, 6'd5, 16'hFFFF, 4'd13);// R13 idle code
    run_op(1, 1, 5'd28, 8'hAA, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4
    run_op(1, 1, 5'd29, 8'h55, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4
    run_op(0, 0, 5'd0,  8'h00, 3'd3, 5'd28, 5'd0, 6'h10, 16'h0, 4'd8);// R8 no borrow
    run_op(1, 1, 5'd26, 8'h05, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd4); // R4
    run_op(0, 0, 5'd0,  8'h00, 3'd3, 5'd26, 5'd0, 6'h10, 16'h0, 4'd8);// R8 borrow
    run_op(0, 0, 5'd0,  8'h00, 3'd2, 5'd22, 5'd0, 6'd1, 16'h0, 4'd9); // R9 below window
    run_op(0, 0, 5'd0,  8'h00, 3'd2, 5'd25, 5'd0, 6'd1, 16'h0, 4'd9); // R9 odd in window
    run_op(0, 0, 5'd0,  8'h00, 3'd3, 5'd0, 5'd0, 6'd1, 16'h0, 4'd9);  // R9 bottom pair
    run_op(0, 0, 5'd0,  8'h00, 3'd4, 5'd9, 5'd13, 6'd0, 16'h0528, 4'd10);// R10 fixed pair
    run_op(1, 0, 5'd25, 8'hEE, 3'd2, 5'd24, 5'd0, 6'd1, 16'h0, 4'd11);// R11 pair beats byte
    run_op(1, 0, 5'd3,  8'h77, 3'd1, 5'd0, 5'd28, 6'd0, 16'h0, 4'd11);// R11 disjoint both land
    run_op(1, 0, 5'd2,  8'h44, 3'd1, 5'd5, 5'd16, 6'd0, 16'h0, 4'd12);// R12 byte suppressed
    run_op(1, 1, 5'd4,  8'h66, 3'd4, 5'd0, 5'd0, 6'd0, 16'hBEEF, 4'd12);// R12 mul suppressed
    run_op(0, 0, 5'd0,  8'h00, 3'd0, 5'd0, 5'd0, 6'd0, 16'h0, 4'd12);// R12 error gone
    do_reset(4'd1);                                                   // R1 mid-run reset
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule